// File: doc/BRIEF.md
# Signed-Digit Fraction Code Enumerator

The block lists every redundant signed-digit code of a binary fraction m/2^n. A code has one supply digit A0, which is 0 or 1, and n weight digits A1..An, each -1, 0 or +1. Digit Aj carries the weight 2^(n-j). Software or a controlling block loads a resolution n and an odd numerator m and pulses start. The block then walks all 3^n weight-digit combinations, one per clock, in balanced-ternary counting order. For each combination it forms the signed integer sum. A negative sum sets A0 to 1 and is lifted by 2^n. The combination is kept when the lifted sum equals m.

Each kept code leaves through a single-entry valid/ready stream. When the walk is over and the last code has been taken, a done level rises. It comes with the number of codes found and two sanity flags. One flag reports fewer than n+1 codes. The other reports a digit position that holds +1 in some code but -1 in none. An illegal n or m is refused at start, and no code is streamed.

Top module: `sdc_enum_top`

## Requirements
- R1: Each digit is a 2-bit field: 00 means 0, 01 means +1 and 11 means -1. In `code_word`, field i (bits 2i+1:2i, for i < MAX_N) holds digit A(n-i), so that field i carries weight 2^i. Fields with i >= n are 00. The top field (index MAX_N) holds A0 and is 00 or 01.
- R2: Every streamed code satisfies S + A0·2^n = m, where S is the signed weighted sum of its digits. A0 is 1 exactly when S is negative.
- R3: The stream holds every matching combination exactly once, in enumeration order. Combination k gives field i the digit (floor(k/3^i) mod 3) - 1, so k = 0 is all -1 and field 0 changes fastest.
- R4: While `code_valid` is high and `code_ready` is low, `code_valid` stays high and `code_word` stays unchanged.
- R5: A start is refused when m is even (which includes 0), when m >= 2^n, when n = 0 or when n > MAX_N. In that case `done` and `err_param` are high on the cycle after start, `code_count` is 0 and no code is streamed. The next legal start clears `err_param`.
- R6: Once the final combination is evaluated and the output slot is empty, `done` is high and `busy` is low. `code_count` then equals the number of codes streamed, and it only ever steps by one or clears to zero.
- R7: `err_short` is high at done when `code_count` < n+1. For every legal input at least n+1 codes exist, so it stays low.
- R8: `err_pair` is high at done when some position held +1 in a streamed code and -1 in none. For legal inputs it stays low.
- R9: During reset `code_valid`, `busy`, `done`, `code_count` and all error flags are zero.
- R10: With `code_ready` held high, `done` first reads high 3^n+1 clocks after the edge that takes start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; taken only while idle or done |
| cfg_n | input | $clog2(MAX_N+1) | Resolution n |
| cfg_m | input | MAX_N | Numerator m |
| code_valid | output | 1 | A code is presented |
| code_ready | input | 1 | Consumer takes the code |
| code_word | output | 2*MAX_N+2 | Code fields as in R1 |
| busy | output | 1 | Search or drain in progress |
| done | output | 1 | Search finished |
| code_count | output | 2*MAX_N | Codes found in this search |
| err_param | output | 1 | Start refused |
| err_short | output | 1 | Fewer than n+1 codes |
| err_pair | output | 1 | A +1 position without a matching -1 |

## Verification
Some properties are checked on every cycle. These are the encoding of each presented word, its decoded value against the latched numerator, that the word stays still under backpressure, that the count only steps forward, and that no code appears once the block is done or has refused a start. Other properties only the bench can show. It compares the full ordered code list for every odd numerator at each resolution up to five against its own ternary walk. It confirms that no code is lost or duplicated under random backpressure, measures the cycle count of an unstalled run, and shows that each illegal configuration is refused.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DONE  = 2'd3
  } sdc_state_e;

  localparam logic [1:0] DIG_ZERO = 2'b00;
  localparam logic [1:0] DIG_POS  = 2'b01;
  localparam logic [1:0] DIG_NEG  = 2'b11;

  // balanced-ternary digit increment: -1 -> 0 -> +1 -> -1
  function automatic logic [1:0] dig_step(input logic [1:0] d);
    case (d)
      DIG_NEG:  return DIG_ZERO;
      DIG_ZERO: return DIG_POS;
      default:  return DIG_NEG;
    endcase
  endfunction

endpackage

// File: rtl/sdc_tern_cnt.sv
module sdc_tern_cnt
  import sdc_pkg::*;
#(
  parameter int MAX_N = 16,
  parameter int NW    = $clog2(MAX_N + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      init,
  input  logic                      step,
  input  logic [NW-1:0]             init_n,
  output logic [MAX_N-1:0][1:0]     digits,
  output logic                      last
);

  logic [MAX_N-1:0][1:0] dig_q, dig_d;
  logic [MAX_N-1:0]      act_q, act_d;
  logic [MAX_N-1:0]      sat;     // digit inactive or already at +1
  logic [MAX_N-1:0]      carry;   // all lower positions saturated

  always_comb begin
    for (int i = 0; i < MAX_N; i++) begin
      sat[i] = !act_q[i] || (dig_q[i] == DIG_POS);
    end
    for (int i = 0; i < MAX_N; i++) begin
      logic [MAX_N-1:0] low_mask;
      low_mask = (MAX_N'(1) << i) - MAX_N'(1);
      carry[i] = &(sat | ~low_mask);
    end
  end

  assign last = &sat;

  always_comb begin
    dig_d = dig_q;
    act_d = act_q;
    if (init) begin
      for (int i = 0; i < MAX_N; i++) begin
        act_d[i] = (NW'(i) < init_n);
        dig_d[i] = act_d[i] ? DIG_NEG : DIG_ZERO;
      end
    end else if (step) begin
      for (int i = 0; i < MAX_N; i++) begin
        if (act_q[i] && carry[i]) dig_d[i] = dig_step(dig_q[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_q <= '0;
      act_q <= '0;
    end else if (init || step) begin
      dig_q <= dig_d;
      act_q <= act_d;
    end
  end

  assign digits = dig_q;

endmodule

// File: rtl/sdc_eval.sv
module sdc_eval
  import sdc_pkg::*;
#(
  parameter int MAX_N = 16,
  parameter int NW    = $clog2(MAX_N + 1)
) (
  input  logic [MAX_N-1:0][1:0]   digits,
  input  logic [NW-1:0]           n_q,
  input  logic [MAX_N-1:0]        m_q,
  output logic [2*MAX_N+1:0]      word,
  output logic                    match
);

  localparam int SW = MAX_N + 2;

  logic [SW-1:0] terms [MAX_N];
  logic [SW-1:0] fsum, wrap, adj;
  logic          neg;

  for (genvar i = 0; i < MAX_N; i++) begin : g_term
    assign terms[i] = (digits[i] == DIG_POS) ?  (SW'(1) << i) :
                      (digits[i] == DIG_NEG) ? -(SW'(1) << i) : '0;
  end

  always_comb begin
    fsum = '0;
    for (int i = 0; i < MAX_N; i++) fsum = fsum + terms[i];
  end

  assign neg   = fsum[SW-1];
  assign wrap  = SW'(1) << n_q;
  assign adj   = neg ? (fsum + wrap) : fsum;
  assign match = (adj == {2'b00, m_q});
  assign word  = {(neg ? DIG_POS : DIG_ZERO), digits};

endmodule

// File: rtl/sdc_tally.sv
module sdc_tally
  import sdc_pkg::*;
#(
  parameter int MAX_N = 16,
  parameter int NW    = $clog2(MAX_N + 1),
  parameter int CW    = 2 * MAX_N
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    load,
  input  logic [MAX_N-1:0][1:0]   digits,
  input  logic [NW-1:0]           n_q,
  output logic [CW-1:0]           count,
  output logic                    short_flag,
  output logic                    pair_flag
);

  logic [CW-1:0]    count_q, count_d;
  logic [MAX_N-1:0] plus_q, plus_d, minus_q, minus_d;

  always_comb begin
    count_d = count_q;
    plus_d  = plus_q;
    minus_d = minus_q;
    if (clear) begin
      count_d = '0;
      plus_d  = '0;
      minus_d = '0;
    end else if (load) begin
      count_d = count_q + CW'(1);
      for (int i = 0; i < MAX_N; i++) begin
        if (digits[i] == DIG_POS) plus_d[i]  = 1'b1;
        if (digits[i] == DIG_NEG) minus_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      plus_q  <= '0;
      minus_q <= '0;
    end else if (clear || load) begin
      count_q <= count_d;
      plus_q  <= plus_d;
      minus_q <= minus_d;
    end
  end

  assign count      = count_q;
  assign short_flag = (count_q < (CW'(n_q) + CW'(1)));
  assign pair_flag  = |(plus_q & ~minus_q);

endmodule

// File: rtl/sdc_enum_top.sv
module sdc_enum_top
  import sdc_pkg::*;
#(
  parameter  int MAX_N = 16,
  localparam int NW    = $clog2(MAX_N + 1),
  localparam int WW    = 2 * MAX_N + 2,
  localparam int CW    = 2 * MAX_N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NW-1:0]   cfg_n,
  input  logic [MAX_N-1:0] cfg_m,
  output logic            code_valid,
  input  logic            code_ready,
  output logic [WW-1:0]   code_word,
  output logic            busy,
  output logic            done,
  output logic [CW-1:0]   code_count,
  output logic            err_param,
  output logic            err_short,
  output logic            err_pair
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n = rs_q[1];

  sdc_state_e            state_q, state_d;
  logic [NW-1:0]         n_q;
  logic [MAX_N-1:0]      m_q;
  logic                  perr_q;
  logic                  out_valid_q, out_valid_d;
  logic [WW-1:0]         out_word_q;

  logic                  cfg_ok, accept, slot_free, adv, load, step, init;
  logic [MAX_N-1:0][1:0] digits;
  logic                  last, match;
  logic [WW-1:0]         cand_word;
  logic                  t_short, t_pair;

  assign cfg_ok = (cfg_n != '0) && (cfg_n <= NW'(MAX_N)) && cfg_m[0] &&
                  ((cfg_m >> cfg_n) == '0);
  assign accept    = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign init      = accept && cfg_ok;
  assign slot_free = !out_valid_q || code_ready;
  assign adv       = (state_q == ST_RUN) && slot_free;
  assign load      = adv && match;
  assign step      = adv && !last;

  sdc_tern_cnt #(.MAX_N(MAX_N), .NW(NW)) u_cnt (
    .clk    (clk),
    .rst_n  (arst_n),
    .init   (init),
    .step   (step),
    .init_n (cfg_n),
    .digits (digits),
    .last   (last)
  );

  sdc_eval #(.MAX_N(MAX_N), .NW(NW)) u_eval (
    .digits (digits),
    .n_q    (n_q),
    .m_q    (m_q),
    .word   (cand_word),
    .match  (match)
  );

  sdc_tally #(.MAX_N(MAX_N), .NW(NW), .CW(CW)) u_tally (
    .clk        (clk),
    .rst_n      (arst_n),
    .clear      (accept),
    .load       (load),
    .digits     (digits),
    .n_q        (n_q),
    .count      (code_count),
    .short_flag (t_short),
    .pair_flag  (t_pair)
  );

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_DONE: if (accept) state_d = cfg_ok ? ST_RUN : ST_DONE;
      ST_RUN:           if (adv && last) state_d = ST_FLUSH;
      ST_FLUSH:         if (slot_free) state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    out_valid_d = out_valid_q;
    if (load)            out_valid_d = 1'b1;
    else if (code_ready) out_valid_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q     <= ST_IDLE;
      out_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      out_valid_q <= out_valid_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      n_q    <= '0;
      m_q    <= '0;
      perr_q <= 1'b0;
    end else if (accept) begin
      n_q    <= cfg_n;
      m_q    <= cfg_m;
      perr_q <= !cfg_ok;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   out_word_q <= '0;
    else if (load) out_word_q <= cand_word;
  end

  assign code_valid = out_valid_q;
  assign code_word  = out_word_q;
  assign busy       = (state_q == ST_RUN) || (state_q == ST_FLUSH);
  assign done       = (state_q == ST_DONE);
  assign err_param  = done && perr_q;
  assign err_short  = done && !perr_q && t_short;
  assign err_pair   = done && !perr_q && t_pair;

endmodule

// File: rtl/sdc_enum_chk.sv
module sdc_enum_chk #(
  parameter  int MAX_N = 16,
  localparam int NW    = $clog2(MAX_N + 1),
  localparam int WW    = 2 * MAX_N + 2,
  localparam int CW    = 2 * MAX_N
) (
  input logic             clk,
  input logic             rst_n,
  input logic             code_valid,
  input logic             code_ready,
  input logic [WW-1:0]    code_word,
  input logic             busy,
  input logic             done,
  input logic [CW-1:0]    code_count,
  input logic             err_param,
  input logic [NW-1:0]    n_q,
  input logic [MAX_N-1:0] m_q
);

  function automatic int word_value(input logic [WW-1:0] w, input logic [NW-1:0] n);
    int v = 0;
    for (int i = 0; i < MAX_N; i++) begin
      if (w[2*i +: 2] == 2'b01) v = v + (1 << i);
      if (w[2*i +: 2] == 2'b11) v = v - (1 << i);
    end
    if (w[WW-2 +: 2] == 2'b01) v = v + (1 << int'(n));
    return v;
  endfunction

  function automatic logic fields_ok(input logic [WW-1:0] w, input logic [NW-1:0] n);
    logic ok = 1'b1;
    for (int i = 0; i < MAX_N; i++) begin
      if (w[2*i +: 2] == 2'b10) ok = 1'b0;
      if ((i >= int'(n)) && (w[2*i +: 2] != 2'b00)) ok = 1'b0;
    end
    if (w[WW-1]) ok = 1'b0;
    return ok;
  endfunction

  AST_FIELD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> fields_ok(code_word, n_q)); // R1

  AST_VALUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> (word_value(code_word, n_q) == int'(m_q))); // R2

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && !code_ready) |=> (code_valid && $stable(code_word))); // R4

  AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_param |-> (!code_valid && (code_count == '0))); // R5

  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!code_valid && !busy)); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (code_count != $past(code_count)) |->
      ((code_count == $past(code_count) + CW'(1)) || (code_count == '0))); // R6

endmodule

bind sdc_enum_top sdc_enum_chk #(.MAX_N(MAX_N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .code_valid (code_valid),
  .code_ready (code_ready),
  .code_word  (code_word),
  .busy       (busy),
  .done       (done),
  .code_count (code_count),
  .err_param  (err_param),
  .n_q        (n_q),
  .m_q        (m_q)
);

// File: tb/sim_sdc_enum_top.sv
`timescale 1ns/1ps
module sim_sdc_enum_top;

  localparam int MN = 5;
  localparam int NW = $clog2(MN + 1);
  localparam int WW = 2 * MN + 2;
  localparam int CW = 2 * MN;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic [NW-1:0]   cfg_n;
  logic [MN-1:0]   cfg_m;
  logic            code_valid;
  logic            code_ready;
  logic [WW-1:0]   code_word;
  logic            busy, done;
  logic [CW-1:0]   code_count;
  logic            err_param, err_short, err_pair;

  int checks = 0;
  int fails  = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  sdc_enum_top #(.MAX_N(MN)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_n(cfg_n), .cfg_m(cfg_m),
    .code_valid(code_valid), .code_ready(code_ready), .code_word(code_word),
    .busy(busy), .done(done), .code_count(code_count),
    .err_param(err_param), .err_short(err_short), .err_pair(err_pair)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int pow3(input int n);
    int p = 1;
    for (int i = 0; i < n; i++) p = p * 3;
    return p;
  endfunction

  function automatic int combo_sum(input int n, input int idx);
    int t = idx;
    int f = 0;
    for (int i = 0; i < n; i++) begin
      f = f + ((t % 3) - 1) * (1 << i);
      t = t / 3;
    end
    return f;
  endfunction

  function automatic bit combo_match(input int n, input int m, input int idx);
    int f = combo_sum(n, idx);
    if (f < 0) f = f + (1 << n);
    return (f == m);
  endfunction

  function automatic logic [WW-1:0] combo_word(input int n, input int idx);
    logic [WW-1:0] w = '0;
    int t = idx;
    for (int i = 0; i < n; i++) begin
      int d = (t % 3) - 1;
      t = t / 3;
      w[2*i +: 2] = (d == 1) ? 2'b01 : (d == -1) ? 2'b11 : 2'b00;
    end
    if (combo_sum(n, idx) < 0) w[WW-2 +: 2] = 2'b01;
    return w;
  endfunction

  task automatic run_case(input int n, input int m, input bit rnd);
    int total = 0;
    int exp_idx = 0;
    int got = 0;
    int k = 0;
    int lim = pow3(n) * 4 + 50;
    bit hold_prev = 1'b0;
    logic [WW-1:0] prev_word = '0;
    for (int i = 0; i < pow3(n); i++) if (combo_match(n, m, i)) total++;
    cfg_n = NW'(n);
    cfg_m = MN'(m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (k < lim) begin
      @(negedge clk);
      k++;
      if (hold_prev)
        chk(code_valid && (code_word == prev_word), "R4", "word held under stall",
            longint'(code_word), longint'(prev_word));
      if (done) break;
      if (rnd) begin
        code_ready = lfsr[0] | lfsr[3];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end else begin
        code_ready = 1'b1;
      end
      if (code_valid && code_ready) begin
        int idx = exp_idx;
        while (idx < pow3(n) && !combo_match(n, m, idx)) idx++;
        if (idx >= pow3(n)) begin
          chk(1'b0, "R3", "extra code", longint'(code_word), 0);
        end else begin
          chk(code_word == combo_word(n, idx), "R1 R2 R3", "code word",
              longint'(code_word), longint'(combo_word(n, idx)));
          exp_idx = idx + 1;
        end
        got++;
      end
      hold_prev = code_valid && !code_ready;
      prev_word = code_word;
    end
    chk(done == 1'b1, "R6", "done reached", longint'(done), 1);
    chk(got == total, "R3", "codes received", got, total);
    chk(int'(code_count) == total, "R6", "code count", longint'(code_count), total);
    chk(!busy && !code_valid, "R6", "idle at done", longint'({busy, code_valid}), 0);
    chk(!err_param, "R5", "no refusal", longint'(err_param), 0);
    chk(!err_short && total >= n + 1, "R7", "short flag", longint'(err_short), 0);
    chk(!err_pair, "R8", "pair flag", longint'(err_pair), 0);
    if (!rnd) chk(k == pow3(n) + 1, "R10", "cycles to done", k, pow3(n) + 1);
    code_ready = 1'b1;
  endtask

  task automatic bad_case(input int n, input int m);
    cfg_n = NW'(n);
    cfg_m = MN'(m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && err_param, "R5", "refused start", longint'({done, err_param}), 3);
    chk(code_count == '0, "R5", "count after refusal", longint'(code_count), 0);
    chk(!err_short && !err_pair, "R5", "no run flags", longint'({err_short, err_pair}), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!code_valid && !busy, "R5", "no stream after refusal",
          longint'({code_valid, busy}), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    cfg_n = '0;
    cfg_m = '0;
    code_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!code_valid && !busy && !done && code_count == '0, "R9", "reset outputs",
        longint'({code_valid, busy, done}), 0);
    chk(!err_param && !err_short && !err_pair, "R9", "reset flags",
        longint'({err_param, err_short, err_pair}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    bad_case(3, 4);   // even
    bad_case(3, 0);   // zero
    bad_case(3, 9);   // beyond 2^n
    bad_case(2, 5);   // beyond 2^n
    bad_case(0, 1);   // n = 0
    bad_case(6, 1);   // n above MAX_N

    for (int n = 1; n <= MN; n++) begin
      for (int m = 1; m < (1 << n); m += 2) begin
        if (n <= 3) begin
          run_case(n, m, 1'b0);
          run_case(n, m, 1'b1);
        end else begin
          run_case(n, m, ((m >> 1) & 1) == 1);
        end
      end
    end

    bad_case(4, 6);
    run_case(4, 7, 1'b0);  // refusal cleared by a legal start

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule